// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block tracks the coherence state of every line of one private cache that sits on a shared snooping bus. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. Processor reads and writes are checked against the line state. A hit completes in the same cycle. A miss, or a write to a line that other caches may also hold, raises one bus request. The request stays up until the bus grants it. While a fill is granted, the bus reports whether another cache holds the line. That report decides whether a read fill lands in Exclusive or in Shared.

Transactions from other caches reach the block on a snoop port. The block reports at once whether it holds the snooped line, and it downgrades or invalidates the line. If the line is dirty, the block raises a writeback command. When the other cache is reading, the command also carries an intervention flag so that this cache supplies the data. A line being written back keeps its Modified state until the writeback is acknowledged. A snoop always wins over a pending processor miss. The miss is withdrawn and is evaluated again against the updated state. The data storage, bus arbitration and ordering rules live outside this block. A lookup port lets the surrounding pipeline read the state of any line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 2'b00; Shared 2'b01, Exclusive 2'b10, Modified 2'b11 on `lookup_state`), and `bus_req_valid`, `wb_valid` and `cpu_done` are low while `snoop_ready` is high.
- R2: A processor read of an Invalid line raises `bus_req_valid` with command READ (2'b01) on the next cycle. In the cycle `bus_gnt` is high, `cpu_done` is high. The line then becomes Exclusive if `bus_shared` was low in that cycle, or Shared if it was high.
- R3: A processor write to an Invalid line raises a read-for-ownership request (command 2'b10). After the grant the line is Modified.
- R4: A read of a Shared, Exclusive or Modified line, or a write to a Modified line, completes with `cpu_done` in the request cycle and raises no bus request. The state is unchanged.
- R5: A write to an Exclusive line completes in the request cycle without any bus request, and the line becomes Modified.
- R6: A write to a Shared line raises an upgrade (intent-to-write) request (command 2'b11). After the grant the line is Modified.
- R7: A snooped read (`snoop_cmd`=0) of a Modified line raises `wb_valid` with `wb_intervene` high and `wb_idx` set to the line. These hold until `wb_ack`. The line reads Modified until the acknowledge and Shared afterwards.
- R8: A snooped intent-to-write (`snoop_cmd`=1) of a Modified line raises `wb_valid` with `wb_intervene` low. After `wb_ack` the line is Invalid.
- R9: A snooped read moves an Exclusive line to Shared and leaves a Shared line Shared. A snooped intent-to-write moves an Exclusive or Shared line to Invalid. A snoop of an Invalid line changes nothing. None of these raises a writeback.
- R10: `snoop_hit` is high in the same cycle as `snoop_valid` exactly when the snooped line is not Invalid.
- R11: A snoop accepted while a bus request is pending withdraws that request on the next cycle. The processor request, still held, is then evaluated again against the updated state. For example, an upgrade whose Shared line was invalidated becomes a read-for-ownership.
- R12: While a writeback is pending, `snoop_ready` is low and no processor request completes.
- R13: `bus_gnt` with no bus request pending has no effect on any line state and does not raise `cpu_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line addressed by the processor |
| cpu_done | output | 1 | Processor request completes this cycle |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 upgrade |
| bus_req_idx | output | IDX_W | Line of the bus request |
| bus_gnt | input | 1 | Bus request is granted and completes this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled with `bus_gnt`) |
| snoop_valid | input | 1 | Transaction from another cache observed |
| snoop_cmd | input | 1 | 0 read, 1 intent-to-write |
| snoop_idx | input | IDX_W | Line of the snooped transaction |
| snoop_ready | output | 1 | Snoop is accepted this cycle |
| snoop_hit | output | 1 | This cache holds the snooped line |
| wb_valid | output | 1 | Writeback command pending |
| wb_idx | output | IDX_W | Line to write back |
| wb_intervene | output | 1 | This cache supplies the data to the reader |
| wb_ack | input | 1 | Writeback completes this cycle |
| lookup_idx | input | IDX_W | Line whose state is read out |
| lookup_state | output | 2 | State of line `lookup_idx` |

## Verification
The bench goes after a snoop that arrives while an upgrade is pending on the same line. A design that did not retry would turn an Invalid line into Modified without fetching it. The bench watches the fill grant with `bus_shared` both high and low; a design that ignored the signal would leave a shared line Exclusive and later write it silently. It checks that a line being written back still reads Modified and refuses snoops and processor hits until the acknowledge, where a premature update would let another transaction see a clean line with dirty data outstanding. It also checks the intervention flag on each dirty snoop and the silent Exclusive-to-Modified write.

// File: rtl/mesi_pkg.sv
// Package: shared encodings for the line coherence controller.
// Assumes two-bit state and bus command codes; the values are visible at
// the top-level ports and must not be reordered.
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_E = 2'b10,
        LS_M = 2'b11
    } line_state_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'b00,
        BC_READ = 2'b01,
        BC_RFO  = 2'b10,
        BC_UPGR = 2'b11
    } bus_cmd_t;

    localparam logic SNP_READ = 1'b0;
    localparam logic SNP_ITW  = 1'b1;

endpackage

// File: rtl/mesi_state_array.sv
// Module: per-line state storage with one write port and three read ports
// (processor, snoop, lookup). Assumes at most one write per cycle, which the
// controller guarantees. All lines reset to Invalid.
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  line_state_t          wr_state,
    input  logic [IDX_W-1:0]     cpu_idx,
    output line_state_t          cpu_state,
    input  logic [IDX_W-1:0]     snp_idx,
    output line_state_t          snp_state,
    input  logic [IDX_W-1:0]     look_idx,
    output line_state_t          look_state
);

    line_state_t lines [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Holds the state of one line; loaded when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lines[g] <= LS_I;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                lines[g] <= wr_state;
            end
        end
    end

    // Combinational read ports.
    always_comb begin
        cpu_state  = lines[cpu_idx];
        snp_state  = lines[snp_idx];
        look_state = lines[look_idx];
    end

endmodule

// File: rtl/mesi_transition.sv
// Module: pure next-state logic of the four-state protocol. Assumes the
// caller applies each result only when the matching event is taken.
module mesi_transition
    import mesi_pkg::*;
(
    input  line_state_t cpu_state,
    input  logic        cpu_write,
    output logic        cpu_hit,
    output line_state_t cpu_next,
    output bus_cmd_t    miss_cmd,
    input  bus_cmd_t    fill_cmd,
    input  logic        fill_shared,
    output line_state_t fill_state,
    input  line_state_t snp_state,
    input  logic        snp_cmd,
    output line_state_t snp_next,
    output logic        snp_wb,
    output logic        snp_intervene
);

    // Processor side: hit decision, silent upgrade and miss command.
    always_comb begin
        cpu_hit  = 1'b0;
        cpu_next = cpu_state;
        miss_cmd = BC_NONE;
        unique case (cpu_state)
            LS_M: cpu_hit = 1'b1;
            LS_E: begin
                cpu_hit = 1'b1;
                if (cpu_write) cpu_next = LS_M;
            end
            LS_S: begin
                if (cpu_write) miss_cmd = BC_UPGR;
                else           cpu_hit  = 1'b1;
            end
            default: miss_cmd = cpu_write ? BC_RFO : BC_READ;
        endcase
    end

    // Fill side: state installed when a bus request is granted.
    always_comb begin
        if (fill_cmd == BC_READ) fill_state = fill_shared ? LS_S : LS_E;
        else                     fill_state = LS_M;
    end

    // Snoop side: downgrade or invalidate, writeback for dirty lines.
    always_comb begin
        snp_next      = snp_state;
        snp_wb        = (snp_state == LS_M);
        snp_intervene = (snp_state == LS_M) && (snp_cmd == SNP_READ);
        if (snp_state != LS_I) begin
            snp_next = (snp_cmd == SNP_ITW) ? LS_I : LS_S;
        end
    end

endmodule

// File: rtl/mesi_seq_ctrl.sv
// Module: sequencing FSM. Serves processor requests, holds one bus request
// and one writeback, and gives snoops priority over a pending miss (the miss
// is dropped and re-evaluated). Assumes the processor holds its request until
// cpu_done and that the array accepts one write per cycle.
module mesi_seq_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic [IDX_W-1:0] cpu_req_idx,
    input  logic             cpu_hit,
    input  line_state_t      cpu_state,
    input  line_state_t      cpu_next,
    input  bus_cmd_t         miss_cmd,
    output logic             cpu_done,
    output logic             bus_req_valid,
    output bus_cmd_t         pend_cmd,
    output logic [IDX_W-1:0] pend_idx,
    input  logic             bus_gnt,
    input  line_state_t      fill_state,
    input  logic             snoop_valid,
    input  logic [IDX_W-1:0] snoop_idx,
    input  line_state_t      snp_state,
    input  line_state_t      snp_next,
    input  logic             snp_wb,
    input  logic             snp_intervene,
    output logic             snoop_ready,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic             wb_intervene,
    input  logic             wb_ack,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output line_state_t      wr_state
);

    typedef enum logic [1:0] {C_IDLE, C_MISS, C_WB} ctrl_t;

    ctrl_t       st, st_nxt;
    logic        load_miss, load_wb;
    line_state_t wb_next;

    // Next-state and array-write decision for the current cycle.
    always_comb begin
        st_nxt    = st;
        load_miss = 1'b0;
        load_wb   = 1'b0;
        cpu_done  = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = cpu_req_idx;
        wr_state  = cpu_next;
        if ((st != C_WB) && snoop_valid) begin
            wr_idx = snoop_idx;
            wr_state = snp_next;
            if (snp_wb) begin
                load_wb = 1'b1;
                st_nxt  = C_WB;
            end else begin
                wr_en  = (snp_next != snp_state);
                st_nxt = C_IDLE;
            end
        end else begin
            unique case (st)
                C_IDLE: begin
                    if (cpu_req_valid) begin
                        if (cpu_hit) begin
                            cpu_done = 1'b1;
                            wr_en    = (cpu_next != cpu_state);
                        end else begin
                            load_miss = 1'b1;
                            st_nxt    = C_MISS;
                        end
                    end
                end
                C_MISS: begin
                    if (bus_gnt) begin
                        cpu_done = 1'b1;
                        wr_en    = 1'b1;
                        wr_idx   = pend_idx;
                        wr_state = fill_state;
                        st_nxt   = C_IDLE;
                    end
                end
                default: begin
                    wr_idx   = wb_idx;
                    wr_state = wb_next;
                    if (wb_ack) begin
                        wr_en  = 1'b1;
                        st_nxt = C_IDLE;
                    end
                end
            endcase
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nxt;
    end

    // Captures the pending bus request when a miss is detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cmd <= BC_NONE;
            pend_idx <= '0;
        end else if (load_miss) begin
            pend_cmd <= miss_cmd;
            pend_idx <= cpu_req_idx;
        end
    end

    // Captures the writeback command and the state applied on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_idx       <= '0;
            wb_intervene <= 1'b0;
            wb_next      <= LS_I;
        end else if (load_wb) begin
            wb_idx       <= snoop_idx;
            wb_intervene <= snp_intervene;
            wb_next      <= snp_next;
        end
    end

    // Handshake outputs decoded from the sequencer state.
    always_comb begin
        bus_req_valid = (st == C_MISS);
        wb_valid      = (st == C_WB);
        snoop_ready   = (st != C_WB);
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
// Module: top of the line coherence controller. Connects the state array,
// the protocol transition logic and the sequencer. Assumes line indices
// select lines directly (tag matching happens outside).
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    input  logic             cpu_req_write,
    input  logic [IDX_W-1:0] cpu_req_idx,
    output logic             cpu_done,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_cmd,
    output logic [IDX_W-1:0] bus_req_idx,
    input  logic             bus_gnt,
    input  logic             bus_shared,
    input  logic             snoop_valid,
    input  logic             snoop_cmd,
    input  logic [IDX_W-1:0] snoop_idx,
    output logic             snoop_ready,
    output logic             snoop_hit,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic             wb_intervene,
    input  logic             wb_ack,
    input  logic [IDX_W-1:0] lookup_idx,
    output logic [1:0]       lookup_state
);

    line_state_t      cpu_state, snp_state, look_state;
    line_state_t      cpu_next, fill_state, snp_next, wr_state;
    bus_cmd_t         miss_cmd, pend_cmd;
    logic             cpu_hit, snp_wb, snp_intervene, wr_en;
    logic [IDX_W-1:0] wr_idx;

    mesi_state_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .cpu_idx    (cpu_req_idx),
        .cpu_state  (cpu_state),
        .snp_idx    (snoop_idx),
        .snp_state  (snp_state),
        .look_idx   (lookup_idx),
        .look_state (look_state)
    );

    mesi_transition u_trans (
        .cpu_state     (cpu_state),
        .cpu_write     (cpu_req_write),
        .cpu_hit       (cpu_hit),
        .cpu_next      (cpu_next),
        .miss_cmd      (miss_cmd),
        .fill_cmd      (pend_cmd),
        .fill_shared   (bus_shared),
        .fill_state    (fill_state),
        .snp_state     (snp_state),
        .snp_cmd       (snoop_cmd),
        .snp_next      (snp_next),
        .snp_wb        (snp_wb),
        .snp_intervene (snp_intervene)
    );

    mesi_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_idx   (cpu_req_idx),
        .cpu_hit       (cpu_hit),
        .cpu_state     (cpu_state),
        .cpu_next      (cpu_next),
        .miss_cmd      (miss_cmd),
        .cpu_done      (cpu_done),
        .bus_req_valid (bus_req_valid),
        .pend_cmd      (pend_cmd),
        .pend_idx      (bus_req_idx),
        .bus_gnt       (bus_gnt),
        .fill_state    (fill_state),
        .snoop_valid   (snoop_valid),
        .snoop_idx     (snoop_idx),
        .snp_state     (snp_state),
        .snp_next      (snp_next),
        .snp_wb        (snp_wb),
        .snp_intervene (snp_intervene),
        .snoop_ready   (snoop_ready),
        .wb_valid      (wb_valid),
        .wb_idx        (wb_idx),
        .wb_intervene  (wb_intervene),
        .wb_ack        (wb_ack),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_state      (wr_state)
    );

    // Port-level outputs: snoop hit report, request command and lookup.
    always_comb begin
        snoop_hit    = snoop_valid && (snp_state != LS_I);
        bus_req_cmd  = pend_cmd;
        lookup_state = look_state;
    end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
// Module: protocol checker for mesi_line_ctrl, attached by bind. Observes
// top-level ports only.
module mesi_line_ctrl_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_done,
    input logic             bus_req_valid,
    input logic [1:0]       bus_req_cmd,
    input logic [IDX_W-1:0] bus_req_idx,
    input logic             bus_gnt,
    input logic             snoop_valid,
    input logic             snoop_ready,
    input logic             snoop_hit,
    input logic             wb_valid,
    input logic [IDX_W-1:0] wb_idx,
    input logic             wb_intervene,
    input logic             wb_ack
);

    // R1: leaving reset, no request or writeback is pending.
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_req_valid && !wb_valid));

    // R2: an ungranted, unsnooped request holds its command and line.
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_gnt && !snoop_valid) |=>
        (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_idx)));

    // R2: a pending request always carries a real command.
    a_r2_cmd_known: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_cmd != 2'b00));

    // R7: an unacknowledged writeback holds its line and intervention flag.
    a_r7_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=>
        (wb_valid && $stable(wb_idx) && $stable(wb_intervene)));

    // R10: a hit is only reported for a present snoop.
    a_r10_hit_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_hit |-> snoop_valid);

    // R11: an accepted snoop withdraws the pending request.
    a_r11_snoop_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_ready && bus_req_valid) |=> !bus_req_valid);

    // R12: snoops are refused and the processor is stalled during writeback.
    a_r12_wb_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (!snoop_ready && !cpu_done));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/100ps
// Bench: directed corner cases plus seeded random traffic, checked against
// a reference model of the line states kept in the bench.
module mesi_line_ctrl_test;

    localparam int NL = 4;
    localparam int IW = 2;
    localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;
    localparam logic [1:0] CRD = 2'b01, CRFO = 2'b10, CUPG = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 0, cpu_req_write = 0;
    logic [IW-1:0] cpu_req_idx = '0;
    logic cpu_done, bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [IW-1:0] bus_req_idx;
    logic bus_gnt = 0, bus_shared = 0;
    logic snoop_valid = 0, snoop_cmd = 0;
    logic [IW-1:0] snoop_idx = '0;
    logic snoop_ready, snoop_hit, wb_valid, wb_intervene;
    logic [IW-1:0] wb_idx;
    logic wb_ack = 0;
    logic [IW-1:0] lookup_idx = '0;
    logic [1:0] lookup_state;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [1:0] model [NL];

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected command for a processor miss, none for a hit.
    function automatic logic [1:0] exp_cmd(input logic [1:0] s, input logic w);
        if (s == SI) return w ? CRFO : CRD;
        if (s == SS && w) return CUPG;
        return 2'b00;
    endfunction

    function automatic logic [1:0] exp_fill(input logic [1:0] cmd, input logic sh);
        if (cmd == CRD) return sh ? SS : SE;
        return SM;
    endfunction

    function automatic logic [1:0] exp_snoop(input logic [1:0] s, input logic c);
        if (s == SI) return SI;
        return c ? SI : SS;
    endfunction

    task automatic check_lines(input string req);
        for (int i = 0; i < NL; i++) begin
            lookup_idx = IW'(i);
            #0.1;
            chk(req, lookup_state, model[i]);
        end
    endtask

    // Processor access; called at a negative edge, returns at a negative edge.
    task automatic cpu_op(input int idx, input logic w, input logic sh, input int dly);
        logic [1:0] cmd;
        cmd = exp_cmd(model[idx], w);
        cpu_req_valid = 1; cpu_req_write = w; cpu_req_idx = IW'(idx);
        #0.5;
        if (cmd == 2'b00) begin
            chk(w && model[idx] == SE ? "R5 done" : "R4 hit done", cpu_done, 1);
            chk(w && model[idx] == SE ? "R5 no bus" : "R4 no bus", bus_req_valid, 0);
            if (w) model[idx] = SM;
            @(negedge clk);
        end else begin
            chk("R2 miss not done", cpu_done, 0);
            @(negedge clk);
            for (int d = 0; d < dly; d++) begin
                chk("R2 req valid", bus_req_valid, 1);
                @(negedge clk);
            end
            chk(cmd == CRD ? "R2 cmd" : (cmd == CRFO ? "R3 cmd" : "R6 cmd"), bus_req_cmd, cmd);
            chk("R2 req idx", bus_req_idx, idx);
            bus_gnt = 1; bus_shared = sh;
            #0.5;
            chk("R2 done on grant", cpu_done, 1);
            @(negedge clk);
            bus_gnt = 0; bus_shared = 0;
            model[idx] = exp_fill(cmd, sh);
        end
        cpu_req_valid = 0;
        #0.5;
        chk("R2 idle after fill", bus_req_valid, 0);
        check_lines(cmd == CRD ? "R2 fill state" : (cmd == CUPG ? "R6 state" : "R3 state"));
    endtask

    // Snoop from another cache; called and returns at a negative edge.
    task automatic snoop_op(input int idx, input logic c, input int dly);
        logic [1:0] s;
        s = model[idx];
        snoop_valid = 1; snoop_cmd = c; snoop_idx = IW'(idx);
        #0.5;
        chk("R10 snoop hit", snoop_hit, (s != SI));
        chk("R12 ready idle", snoop_ready, 1);
        @(negedge clk);
        snoop_valid = 0;
        #0.5;
        if (s == SM) begin
            chk(c ? "R8 wb valid" : "R7 wb valid", wb_valid, 1);
            chk(c ? "R8 wb idx" : "R7 wb idx", wb_idx, idx);
            chk(c ? "R8 no intervene" : "R7 intervene", wb_intervene, !c);
            chk("R12 snoop blocked", snoop_ready, 0);
            cpu_req_valid = 1; cpu_req_write = 0; cpu_req_idx = IW'(idx);
            #0.2;
            chk("R12 cpu stalled", cpu_done, 0);
            cpu_req_valid = 0;
            check_lines("R7 still modified");
            for (int d = 0; d < dly; d++) @(negedge clk);
            wb_ack = 1;
            @(negedge clk);
            wb_ack = 0;
            #0.5;
            chk("R7 wb done", wb_valid, 0);
        end else begin
            chk("R9 no wb", wb_valid, 0);
        end
        model[idx] = exp_snoop(s, c);
        check_lines(s == SM ? (c ? "R8 state" : "R7 state") : "R9 state");
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < NL; i++) model[i] = SI;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #0.5;
        chk("R1 no req", bus_req_valid, 0);
        chk("R1 no wb", wb_valid, 0);
        chk("R1 no done", cpu_done, 0);
        chk("R1 ready", snoop_ready, 1);
        check_lines("R1 all invalid");
        @(negedge clk);

        // R13: stray grant while idle.
        bus_gnt = 1; bus_shared = 1;
        #0.5;
        chk("R13 no done", cpu_done, 0);
        @(negedge clk);
        bus_gnt = 0; bus_shared = 0;
        check_lines("R13 no change");

        // Directed fills: exclusive, shared, silent upgrade, dirty snoops.
        cpu_op(0, 0, 0, 1);
        cpu_op(1, 0, 1, 0);
        cpu_op(0, 1, 0, 0);
        cpu_op(2, 1, 0, 2);
        snoop_op(0, 0, 1);
        snoop_op(2, 1, 0);
        snoop_op(1, 1, 0);

        // R11: upgrade pending on a Shared line, snooped intent-to-write.
        cpu_op(3, 0, 1, 0);
        cpu_req_valid = 1; cpu_req_write = 1; cpu_req_idx = 2'd3;
        @(negedge clk);
        chk("R6 upgrade cmd", bus_req_cmd, CUPG);
        snoop_valid = 1; snoop_cmd = 1; snoop_idx = 2'd3;
        #0.5;
        chk("R10 hit during miss", snoop_hit, 1);
        @(negedge clk);
        snoop_valid = 0;
        #0.5;
        chk("R11 withdrawn", bus_req_valid, 0);
        @(negedge clk);
        chk("R11 retried", bus_req_valid, 1);
        chk("R11 retry as RFO", bus_req_cmd, CRFO);
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0; cpu_req_valid = 0;
        model[3] = SM;
        check_lines("R11 final state");

        // Random traffic.
        for (int n = 0; n < 400; n++) begin
            int idx;
            idx = int'($urandom_range(NL - 1));
            if ($urandom_range(1) == 0)
                cpu_op(idx, logic'($urandom_range(1)), logic'($urandom_range(1)),
                       int'($urandom_range(2)));
            else
                snoop_op(idx, logic'($urandom_range(1)), int'($urandom_range(2)));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule